// File: doc/BRIEF.md
# Serial Audio Codec Frame Transmitter

This block produces the outgoing serial stream from an audio controller to a codec. Every frame is 256 bit times long: a 16-bit tag header followed by twelve 20-bit slots. Bits change on the rising edge of the codec-supplied bit clock, which runs at 12.288 MHz, so the rate is 48,000 frames per second. A sync line goes high at the start of each frame, and a one-cycle strobe marks the first bit time.

The host supplies two kinds of data. The first is a register command: a read or write flag, a 7-bit address and 16 bits of data, offered with a valid/ready handshake. The block stores the command and sends it in slots 1 and 2 of the next frame that begins. The second is a pair of 18-bit two's-complement PCM samples, left and right. The block takes these at each frame boundary and sends them in slots 3 and 4. The tag header flags the slots that carry data in the current frame.

Top module: `codec_frame_tx`

## Requirements
- R1: While reset is asserted, `sdata`, `sync` and `frame_start` are 0 and `cmd_ready` is 1.
- R2: After reset is released, `frame_start` is high for exactly one bit time in every 256. That bit time is bit 0 of the frame.
- R3: `sync` is high during bit times 0 to 15 of each frame and low during bit times 16 to 255.
- R4: Bit times 0 to 15 carry the tag, MSB first. The tag bits are:
  - Bit 15 (frame valid) is always 1.
  - Bits 14 and 13 (slots 1 and 2) are 1 only when the frame carries a command.
  - Bits 12 and 11 (slots 3 and 4) are always 1.
  - Bits 10 to 0 are 0.
- R5: Slot 1 occupies bit times 16 to 35 and slot 2 occupies bit times 36 to 55. Both are sent MSB first. For a write command:
  - Slot 1 bit 19 is 0, bits 18 to 12 hold the address, and bits 11 to 0 are 0.
  - Slot 2 bits 19 to 4 hold the data and bits 3 to 0 are 0.
- R6: For a read command, slot 1 bit 19 is 1 and bits 18 to 12 hold the address. Slot 2 is sent as all zeros whatever the data input holds. The slot 2 tag bit is still 1.
- R7: The left sample is sampled at the rising edge that starts a frame. It fills bits 19 to 2 of slot 3 (bit times 56 to 75), MSB first, and bits 1 to 0 are 0. The right sample is sampled the same way and fills slot 4 (bit times 76 to 95).
- R8: Slots 5 to 12 are always 0. Slots 1 and 2 are 0 in a frame that carries no command.
- R9: A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both 1.
  - `cmd_ready` goes to 0 on the next cycle and returns to 1 in bit time 0 of the next frame to begin.
  - The command is sent in that frame.
  - A command accepted on the edge that starts a frame goes out in the following frame.
- R10: `cmd_valid` has no effect while `cmd_ready` is 0. The command already held is sent unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Codec bit clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Register command offered |
| cmd_read | input | 1 | 1 = register read, 0 = register write |
| cmd_addr | input | 7 | Register address |
| cmd_data | input | 16 | Register write data |
| cmd_ready | output | 1 | Command storage is free |
| pcm_left | input | 18 | Left DAC sample, two's complement |
| pcm_right | input | 18 | Right DAC sample, two's complement |
| sdata | output | 1 | Serial frame data, MSB first |
| sync | output | 1 | Frame sync, high during the tag |
| frame_start | output | 1 | High during bit time 0 of each frame |

## Verification
The hardest case to reach is a command whose acceptance lands exactly on a frame boundary. On that edge the stored command moves into the outgoing frame while a new command is being stored, and the single-cycle window is easy to miss. The bench counts bit times from `frame_start`. It raises `cmd_valid` at bit times 254 and 255 so the command is accepted one cycle before the boundary and exactly on it. It then checks which frame carries each command. A separate test keeps `cmd_valid` high with a different command while `cmd_ready` is low, to show the stored command is not overwritten.

// File: rtl/codec_frame_tx.sv
module codec_frame_tx #(
  parameter int TAG_W  = 16,
  parameter int SLOT_W = 20,
  parameter int SLOTS  = 12,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16,
  parameter int PCM_W  = 18
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_read,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              cmd_ready,
  input  logic [PCM_W-1:0]  pcm_left,
  input  logic [PCM_W-1:0]  pcm_right,
  output logic              sdata,
  output logic              sync,
  output logic              frame_start
);
  localparam int FRAME_W = TAG_W + SLOTS * SLOT_W;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam int A_PAD   = SLOT_W - 1 - ADDR_W;
  localparam int D_PAD   = SLOT_W - DATA_W;
  localparam int P_PAD   = SLOT_W - PCM_W;
  localparam int ZERO_W  = (SLOTS - 4) * SLOT_W;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [CNT_W-1:0]  cnt;
  logic              started;
  logic              pend_vld, pend_rd;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;
  logic              cur_vld, cur_rd;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_data;
  logic [PCM_W-1:0]  cur_left, cur_right;

  wire at_last = (cnt == LAST);

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= LAST;
      started   <= 1'b0;
      pend_vld  <= 1'b0;
      pend_rd   <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
      cur_vld   <= 1'b0;
      cur_rd    <= 1'b0;
      cur_addr  <= '0;
      cur_data  <= '0;
      cur_left  <= '0;
      cur_right <= '0;
    end else begin
      cnt <= at_last ? '0 : cnt + 1'b1;
      if (at_last) begin
        started   <= 1'b1;
        cur_vld   <= pend_vld;
        cur_rd    <= pend_rd;
        cur_addr  <= pend_addr;
        cur_data  <= pend_data;
        cur_left  <= pcm_left;
        cur_right <= pcm_right;
        pend_vld  <= 1'b0;
      end
      if (cmd_valid && !pend_vld) begin
        pend_vld  <= 1'b1;
        pend_rd   <= cmd_read;
        pend_addr <= cmd_addr;
        pend_data <= cmd_data;
      end
    end
  end

  logic [TAG_W-1:0]   tag;
  logic [SLOT_W-1:0]  slot_cmd, slot_dat, slot_l, slot_r;
  logic [FRAME_W-1:0] frame;

  always_comb begin
    tag            = '0;
    tag[TAG_W-1]   = 1'b1;
    tag[TAG_W-2]   = cur_vld;
    tag[TAG_W-3]   = cur_vld;
    tag[TAG_W-4]   = 1'b1;
    tag[TAG_W-5]   = 1'b1;
  end

  assign slot_cmd = cur_vld ? {cur_rd, cur_addr, {A_PAD{1'b0}}} : '0;
  assign slot_dat = (cur_vld && !cur_rd) ? {cur_data, {D_PAD{1'b0}}} : '0;
  assign slot_l   = {cur_left,  {P_PAD{1'b0}}};
  assign slot_r   = {cur_right, {P_PAD{1'b0}}};
  assign frame    = {tag, slot_cmd, slot_dat, slot_l, slot_r, {ZERO_W{1'b0}}};

  assign cmd_ready   = !pend_vld;
  assign sdata       = started && frame[LAST - cnt];
  assign sync        = started && (cnt < CNT_W'(TAG_W));
  assign frame_start = started && (cnt == '0);
endmodule

// File: rtl/codec_frame_tx_chk.sv
module codec_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic sync,
  input logic frame_start,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic sdata
);
  logic [4:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (!sync) run <= '0;
    else if (run != 5'd31) run <= run + 1'b1;
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (!sync && !frame_start && !sdata && cmd_ready));

  a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  a_r3_sync_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync) |-> frame_start);

  a_r3_start_sync: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> sync);

  a_r3_sync_width: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> run < 5'd16);

  a_r9_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  a_r9_ready_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_ready) |-> frame_start);
endmodule

bind codec_frame_tx codec_frame_tx_chk u_chk (
  .clk(bclk), .rst_n(rst_n), .sync(sync), .frame_start(frame_start),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .sdata(sdata)
);

// File: tb/codec_frame_tx_test.sv
`timescale 1ns/1ps
module codec_frame_tx_test;
  logic bclk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_read = 1'b0;
  logic [6:0] cmd_addr = '0;
  logic [15:0] cmd_data = '0;
  logic [17:0] pcm_left = '0, pcm_right = '0;
  logic cmd_ready, sdata, sync, frame_start;
  int checks = 0, failures = 0;
  bit done = 0;
  logic [255:0] got;

  always #2.5 bclk = ~bclk;

  codec_frame_tx uut (
    .bclk(bclk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
    .pcm_left(pcm_left), .pcm_right(pcm_right), .sdata(sdata),
    .sync(sync), .frame_start(frame_start)
  );

  // {valid, read, addr[6:0], data[15:0], left[17:0], right[17:0]}
  localparam logic [60:0] VECS [8] = '{
    {1'b0, 1'b0, 7'h00, 16'h0000, 18'h00001, 18'h3FFFF},
    {1'b1, 1'b0, 7'h02, 16'h8000, 18'h1FFFF, 18'h20000},
    {1'b1, 1'b1, 7'h7F, 16'hFFFF, 18'h2AAAA, 18'h15555},
    {1'b1, 1'b0, 7'h00, 16'h0001, 18'h00000, 18'h00000},
    {1'b1, 1'b0, 7'h55, 16'h1234, 18'h3FFFF, 18'h00001},
    {1'b1, 1'b1, 7'h26, 16'h0000, 18'h12345, 18'h2ABCD},
    {1'b0, 1'b1, 7'h11, 16'hAAAA, 18'h0F0F0, 18'h30303},
    {1'b1, 1'b0, 7'h7F, 16'hFFFF, 18'h20001, 18'h1FFFE}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at the negedge of bit 0; returns at the negedge of bit 255
  task automatic capture();
    int sync_bad = 0, fs_bad = 0;
    for (int i = 0; i < 256; i++) begin
      if (i > 0) @(negedge bclk);
      got[255-i] = sdata;
      if (sync !== (i < 16)) sync_bad++;
      if (frame_start !== (i == 0)) fs_bad++;
    end
    chk("R3 sync pattern errors", sync_bad, 0);
    chk("R2 frame_start pattern errors", fs_bad, 0);
  endtask

  task automatic check_frame(input logic v, input logic rd, input logic [6:0] a,
                             input logic [15:0] d, input logic [17:0] l, input logic [17:0] r);
    logic [15:0] etag;
    logic [19:0] e1, e2;
    etag = {1'b1, v, v, 1'b1, 1'b1, 11'b0};
    e1 = v ? {rd, a, 12'b0} : 20'b0;
    e2 = (v && !rd) ? {d, 4'b0} : 20'b0;
    chk("R4 tag", 32'(got[255:240]), 32'(etag));
    chk(rd ? "R6 slot1 read" : "R5 slot1", 32'(got[239:220]), 32'(e1));
    chk(rd ? "R6 slot2 read zero" : "R5 slot2", 32'(got[219:200]), 32'(e2));
    chk("R7 slot3 left", 32'(got[199:180]), 32'({l, 2'b0}));
    chk("R7 slot4 right", 32'(got[179:160]), 32'({r, 2'b0}));
    chk("R8 slots 5-12 zero", 32'(got[159:0] != '0), 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge bclk);
    chk("R1 sync in reset", sync, 0);
    chk("R1 sdata in reset", sdata, 0);
    chk("R1 frame_start in reset", frame_start, 0);
    chk("R1 cmd_ready in reset", cmd_ready, 1);
    rst_n = 1'b1;
    @(negedge bclk);
    chk("R2 first frame_start", frame_start, 1);

    // table walk: we stand at bit 0 of a frame on entry to each pass
    foreach (VECS[k]) begin
      logic [60:0] vv;
      vv = VECS[k];
      pcm_left = vv[35:18];
      pcm_right = vv[17:0];
      repeat (40) @(negedge bclk);
      if (vv[60]) begin
        cmd_read = vv[59]; cmd_addr = vv[58:52]; cmd_data = vv[51:36];
        cmd_valid = 1'b1;
        chk("R9 ready before accept", cmd_ready, 1);
        @(negedge bclk);
        cmd_valid = 1'b0;
        chk("R9 ready low after accept", cmd_ready, 0);
        repeat (214) @(negedge bclk);
        chk("R9 ready low at bit 255", cmd_ready, 0);
      end else repeat (215) @(negedge bclk);
      @(negedge bclk);
      chk("R2 period 256", frame_start, 1);
      if (vv[60]) chk("R9 ready back at frame start", cmd_ready, 1);
      capture();
      check_frame(vv[60], vv[59], vv[58:52], vv[51:36], vv[35:18], vv[17:0]);
      @(negedge bclk);
    end

    // R10: cmd_valid while not ready leaves the held command alone
    repeat (30) @(negedge bclk);
    cmd_read = 1'b0; cmd_addr = 7'h11; cmd_data = 16'hABCD; cmd_valid = 1'b1;
    @(negedge bclk);
    cmd_read = 1'b1; cmd_addr = 7'h22; cmd_data = 16'h0000;
    repeat (10) @(negedge bclk);
    chk("R10 ready stays low", cmd_ready, 0);
    cmd_valid = 1'b0;
    while (!frame_start) @(negedge bclk);
    capture();
    check_frame(1'b1, 1'b0, 7'h11, 16'hABCD, pcm_left, pcm_right);
    @(negedge bclk);
    capture();
    check_frame(1'b0, 1'b0, 7'h00, 16'h0000, pcm_left, pcm_right); // R4 flags clear
    @(negedge bclk);

    // R9: accepted one edge before the boundary -> next frame
    repeat (254) @(negedge bclk);
    cmd_read = 1'b0; cmd_addr = 7'h33; cmd_data = 16'h5555; cmd_valid = 1'b1;
    @(negedge bclk);
    chk("R9 late accept ready low", cmd_ready, 0);
    // still valid at bit 255: must be ignored while not ready (R10)
    cmd_addr = 7'h01;
    @(negedge bclk);
    cmd_valid = 1'b0;
    chk("R9 ready at frame start", cmd_ready, 1);
    capture();
    check_frame(1'b1, 1'b0, 7'h33, 16'h5555, pcm_left, pcm_right);
    // R9: accepted on the boundary edge itself -> frame after next
    cmd_read = 1'b0; cmd_addr = 7'h44; cmd_data = 16'h0F0F; cmd_valid = 1'b1;
    @(negedge bclk);
    cmd_valid = 1'b0;
    chk("R9 boundary accept ready low", cmd_ready, 0);
    capture();
    check_frame(1'b0, 1'b0, 7'h00, 16'h0000, pcm_left, pcm_right);
    @(negedge bclk);
    chk("R9 boundary ready returns", cmd_ready, 1);
    capture();
    check_frame(1'b1, 1'b0, 7'h44, 16'h0F0F, pcm_left, pcm_right);

    // R1 again mid-operation
    rst_n = 1'b0;
    @(negedge bclk);
    chk("R1 sync after reset", sync, 0);
    chk("R1 frame_start after reset", frame_start, 0);
    chk("R1 ready after reset", cmd_ready, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule